// File: doc/BRIEF.md
# Autonomous Link and Memory Power Controller

This controller chooses the operating point of a chip-to-chipset I/O link and of external DRAM from what the system is doing, with no software in the loop. It watches whether the CPU cores are executing or in deep sleep, whether the graphics engine is rendering or only refreshing the display, and whether the link carries traffic. From these it picks one of four power profiles. Each active profile sets a lane count for each link direction on its own. In the deepest profile the link is disconnected and the DRAM is put in self-refresh.

A change of lane count is never applied to a live link. The controller raises the disconnect request and waits for the PHY to acknowledge it. It then applies the new lane counts, drops the disconnect and waits for the link to report ready before it considers another change. Deep idle is entered only after the link has been quiet for a programmable number of cycles. A wake request leaves self-refresh before the link is reconnected.

Two thermal guards run beside the link sequencer. An over-temperature flag requests a P-state cap. An external memory-hot signal requests memory throttling. Each request persists until its cause has been absent for a programmable number of consecutive cycles.

Top module: `auto_link_pwr`

## Requirements
- R1: After reset both lane counts are 4, disconnect is 0, self-refresh is 0, the P-state cap is 0 and memory throttling is 0.
- R2: While `core_exec_i` is 1 the target profile is up 4 / down 4 lanes, whatever the graphics inputs are (highest priority).
- R3: With `core_exec_i` 0 and `gfx_render_i` 1 the target profile is up 16 / down 16 lanes.
- R4: With only `gfx_display_i` 1 the target profile is up 2 / down 8 lanes.
- R5: With no core or graphics activity, the link is disconnected and self-refresh is set only after `link_idle_i` has been 1 on more than `idle_limit_i` consecutive clock edges. A run of exactly `idle_limit_i` edges does not start entry.
- R6: With no core or graphics activity and `link_idle_i` 0, the lane counts stay at their last active values and disconnect stays 0.
- R7: Lane counts change only in a cycle where disconnect is 1 and was 1 in the previous cycle. Disconnect is held until `disc_ack_i` is seen. After reconnecting, no new change starts until `link_ready_i` is 1.
- R8: On a wake from deep idle, self-refresh is cleared while disconnect is still 1. The block then reaches the profile matching the new activity.
- R9: `over_temp_i` sets `pstate_limit_o` on the next cycle. The cap clears only after `over_temp_i` has been 0 for `hyst_limit_i` consecutive edges (at least one), and any reassertion restarts that count.
- R10: `mem_hot_i` sets `mem_throttle_o` with the same timing and hysteresis as R9. `over_temp_i` alone never sets throttling.
- R11: Self-refresh is never 1 while disconnect is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_exec_i | input | 1 | 1: a core is executing; 0: cores in deep sleep |
| gfx_render_i | input | 1 | Graphics rendering active |
| gfx_display_i | input | 1 | Display refresh active |
| link_idle_i | input | 1 | No traffic on the link this cycle |
| over_temp_i | input | 1 | Die temperature above limit |
| mem_hot_i | input | 1 | External memory over-temperature |
| disc_ack_i | input | 1 | PHY acknowledges link disconnect |
| link_ready_i | input | 1 | PHY reports link trained and usable |
| idle_limit_i | input | CNT_W | Idle cycles required before deep idle |
| hyst_limit_i | input | CNT_W | Clear cycles required to drop a thermal request |
| width_up_o | output | 5 | Upstream lane count (2, 4, 8 or 16) |
| width_dn_o | output | 5 | Downstream lane count |
| link_disc_o | output | 1 | Link disconnect request |
| self_refresh_o | output | 1 | DRAM self-refresh enable |
| pstate_limit_o | output | 1 | P-state cap request |
| mem_throttle_o | output | 1 | Memory throttle request |

## Verification
The bench drives every ordered pair of profiles and every activity combination in both sweep directions. A controller that rewrote lane counts on a connected link, or that got the activity priority wrong, would show wrong widths or a live-link change. The idle threshold is probed one edge short of and exactly at its limit, which catches an off-by-one in deep-idle entry. Withheld acknowledge and ready expose a sequencer that drops disconnect early or chains changes before the link is back. Thermal hysteresis is timed edge by edge for several limits and with a retrigger, so a guard that released early or ignored the restart is caught.

// File: rtl/alp_pkg.sv
package alp_pkg;
  localparam int LANE_W = 5;

  typedef enum logic [1:0] {PRF_DRV, PRF_RENDER, PRF_DISP, PRF_DEEP} prf_e;
  typedef enum logic [2:0] {ST_ACTIVE, ST_DISC, ST_APPLY, ST_RECON, ST_DEEP} st_e;

  typedef struct packed {
    logic [LANE_W-1:0] up;
    logic [LANE_W-1:0] dn;
  } lanes_t;

  function automatic lanes_t prf_lanes(prf_e p);
    lanes_t l;
    case (p)
      PRF_RENDER: begin l.up = LANE_W'(16); l.dn = LANE_W'(16); end
      PRF_DISP:   begin l.up = LANE_W'(2);  l.dn = LANE_W'(8);  end
      default:    begin l.up = LANE_W'(4);  l.dn = LANE_W'(4);  end
    endcase
    return l;
  endfunction
endpackage

// File: rtl/alp_prf_sel.sv
module alp_prf_sel
  import alp_pkg::*;
(
  input  logic core_exec_i,
  input  logic gfx_render_i,
  input  logic gfx_display_i,
  output prf_e target_o
);
  always_comb begin
    if (core_exec_i)        target_o = PRF_DRV;
    else if (gfx_render_i)  target_o = PRF_RENDER;
    else if (gfx_display_i) target_o = PRF_DISP;
    else                    target_o = PRF_DEEP;
  end
endmodule

// File: rtl/alp_idle_tmr.sv
module alp_idle_tmr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  // fires on the edge after limit_i qualifying edges
  assign expired_o = en_i && (cnt_q >= limit_i);
endmodule

// File: rtl/alp_hyst.sv
module alp_hyst #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hold_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b0;
      cnt_q  <= '0;
    end else if (trig_i) begin
      hold_o <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_o) begin
      if (cnt_nxt >= {1'b0, limit_i}) begin
        hold_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_nxt[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/alp_link_seq.sv
module alp_link_seq
  import alp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  prf_e   target_i,
  input  logic   sleep_ok_i,
  input  logic   disc_ack_i,
  input  logic   link_ready_i,
  output lanes_t lanes_o,
  output logic   disc_o,
  output logic   sr_o,
  output logic   active_o
);
  st_e  st_q;
  prf_e cur_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ACTIVE;
      cur_q  <= PRF_DRV;
      pend_q <= PRF_DRV;
    end else begin
      case (st_q)
        ST_ACTIVE: begin
          if (target_i == PRF_DEEP) begin
            if (sleep_ok_i) begin
              st_q   <= ST_DISC;
              pend_q <= PRF_DEEP;
            end
          end else if (target_i != cur_q) begin
            st_q   <= ST_DISC;
            pend_q <= target_i;
          end
        end
        ST_DISC: begin
          if (disc_ack_i) begin
            if (pend_q == PRF_DEEP) begin
              st_q <= ST_DEEP;
            end else begin
              st_q  <= ST_APPLY;
              cur_q <= pend_q;
            end
          end
        end
        ST_APPLY: st_q <= ST_RECON;
        ST_RECON: if (link_ready_i) st_q <= ST_ACTIVE;
        ST_DEEP: begin
          // leave self-refresh while the link is still down
          if (target_i != PRF_DEEP) begin
            st_q   <= ST_APPLY;
            cur_q  <= target_i;
            pend_q <= target_i;
          end
        end
        default: st_q <= ST_ACTIVE;
      endcase
    end
  end

  assign lanes_o  = prf_lanes(cur_q);
  assign disc_o   = (st_q == ST_DISC) || (st_q == ST_APPLY) || (st_q == ST_DEEP);
  assign sr_o     = (st_q == ST_DEEP);
  assign active_o = (st_q == ST_ACTIVE);
endmodule

// File: rtl/auto_link_pwr.sv
module auto_link_pwr
  import alp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_exec_i,
  input  logic              gfx_render_i,
  input  logic              gfx_display_i,
  input  logic              link_idle_i,
  input  logic              over_temp_i,
  input  logic              mem_hot_i,
  input  logic              disc_ack_i,
  input  logic              link_ready_i,
  input  logic [CNT_W-1:0]  idle_limit_i,
  input  logic [CNT_W-1:0]  hyst_limit_i,
  output logic [LANE_W-1:0] width_up_o,
  output logic [LANE_W-1:0] width_dn_o,
  output logic              link_disc_o,
  output logic              self_refresh_o,
  output logic              pstate_limit_o,
  output logic              mem_throttle_o
);
  localparam int N_GUARD = 2;

  prf_e   target;
  logic   seq_active, sleep_ok;
  lanes_t lanes;
  logic [N_GUARD-1:0] guard_trig, guard_hold;

  alp_prf_sel u_sel (
    .core_exec_i  (core_exec_i),
    .gfx_render_i (gfx_render_i),
    .gfx_display_i(gfx_display_i),
    .target_o     (target)
  );

  alp_idle_tmr #(.CNT_W(CNT_W)) u_idle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (seq_active && (target == PRF_DEEP) && link_idle_i),
    .limit_i  (idle_limit_i),
    .expired_o(sleep_ok)
  );

  alp_link_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .target_i    (target),
    .sleep_ok_i  (sleep_ok),
    .disc_ack_i  (disc_ack_i),
    .link_ready_i(link_ready_i),
    .lanes_o     (lanes),
    .disc_o      (link_disc_o),
    .sr_o        (self_refresh_o),
    .active_o    (seq_active)
  );

  assign guard_trig = {mem_hot_i, over_temp_i};

  for (genvar g = 0; g < N_GUARD; g++) begin : g_guard
    alp_hyst #(.CNT_W(CNT_W)) u_hyst (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (guard_trig[g]),
      .limit_i(hyst_limit_i),
      .hold_o (guard_hold[g])
    );
  end

  assign pstate_limit_o = guard_hold[0];
  assign mem_throttle_o = guard_hold[1];
  assign width_up_o     = lanes.up;
  assign width_dn_o     = lanes.dn;
endmodule

// File: rtl/alp_chk.sv
module alp_chk
  import alp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              over_temp_i,
  input logic              mem_hot_i,
  input logic [LANE_W-1:0] width_up_o,
  input logic [LANE_W-1:0] width_dn_o,
  input logic              link_disc_o,
  input logic              self_refresh_o,
  input logic              pstate_limit_o,
  input logic              mem_throttle_o
);
  assert_lane_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_up_o != $past(width_up_o) || width_dn_o != $past(width_dn_o))
      |-> (link_disc_o && $past(link_disc_o)));

  assert_sr_needs_disc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_refresh_o |-> link_disc_o);

  assert_sr_exit_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(self_refresh_o) |-> link_disc_o);

  assert_temp_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_temp_i |=> pstate_limit_o);

  assert_mem_throttle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_hot_i |=> mem_throttle_o);
endmodule

bind auto_link_pwr alp_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/auto_link_pwr_tb.sv
`timescale 1ns/1ps
module auto_link_pwr_tb;
  localparam int CNT_W = 16;

  logic clk = 0, rst_ni = 0;
  logic core_exec_i = 0, gfx_render_i = 0, gfx_display_i = 0, link_idle_i = 0;
  logic over_temp_i = 0, mem_hot_i = 0, disc_ack_i = 0, link_ready_i = 0;
  logic [CNT_W-1:0] idle_limit_i = 3, hyst_limit_i = 5;
  logic [4:0] width_up_o, width_dn_o;
  logic link_disc_o, self_refresh_o, pstate_limit_o, mem_throttle_o;
  logic hold_ack = 0, hold_ready = 0;

  int checks = 0, failures = 0;
  int lane_viol = 0, sr_viol = 0, exit_viol = 0;

  always #5 clk = ~clk;

  auto_link_pwr #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .core_exec_i(core_exec_i), .gfx_render_i(gfx_render_i), .gfx_display_i(gfx_display_i),
    .link_idle_i(link_idle_i), .over_temp_i(over_temp_i), .mem_hot_i(mem_hot_i),
    .disc_ack_i(disc_ack_i), .link_ready_i(link_ready_i),
    .idle_limit_i(idle_limit_i), .hyst_limit_i(hyst_limit_i),
    .width_up_o(width_up_o), .width_dn_o(width_dn_o), .link_disc_o(link_disc_o),
    .self_refresh_o(self_refresh_o), .pstate_limit_o(pstate_limit_o),
    .mem_throttle_o(mem_throttle_o)
  );

  // PHY model: acknowledges and reports ready half a cycle later
  always @(negedge clk) begin
    disc_ack_i   <= link_disc_o & ~hold_ack;
    link_ready_i <= ~link_disc_o & ~hold_ready;
  end

  // port monitor
  logic [4:0] p_up = 4, p_dn = 4;
  logic p_disc = 0, p_sr = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if ((width_up_o != p_up || width_dn_o != p_dn) && !(link_disc_o && p_disc)) lane_viol++;
      if (self_refresh_o && !link_disc_o) sr_viol++;
      if (p_sr && !self_refresh_o && !link_disc_o) exit_viol++;
    end
    p_up = width_up_o; p_dn = width_dn_o; p_disc = link_disc_o; p_sr = self_refresh_o;
  end

  function automatic int exp_up(int p);
    return (p == 0) ? 4 : (p == 1) ? 16 : 2;
  endfunction
  function automatic int exp_dn(int p);
    return (p == 0) ? 4 : (p == 1) ? 16 : 8;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_prf(int p);
    @(negedge clk);
    core_exec_i = (p == 0); gfx_render_i = (p == 1);
    gfx_display_i = (p == 2); link_idle_i = (p == 3);
  endtask

  task automatic check_prf(int p, string req);
    if (p == 3) begin
      chk(self_refresh_o == 1, req, self_refresh_o, 1);
      chk(link_disc_o == 1, req, link_disc_o, 1);
    end else begin
      chk(width_up_o == exp_up(p), req, width_up_o, exp_up(p));
      chk(width_dn_o == exp_dn(p), req, width_dn_o, exp_dn(p));
      chk(link_disc_o == 0, req, link_disc_o, 0);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int last;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(width_up_o == 4, "R1 up", width_up_o, 4);
    chk(width_dn_o == 4, "R1 dn", width_dn_o, 4);
    chk({link_disc_o, self_refresh_o, pstate_limit_o, mem_throttle_o} == 0, "R1 flags",
        {link_disc_o, self_refresh_o, pstate_limit_o, mem_throttle_o}, 0);
    rst_ni = 1;
    settle(4);

    // R2 R3 R4 R6: activity priority sweep, forward then backward
    last = 0;
    for (int k = 0; k < 16; k++) begin
      int c, p;
      c = (k < 8) ? k : 15 - k;
      @(negedge clk);
      core_exec_i = c[2]; gfx_render_i = c[1]; gfx_display_i = c[0]; link_idle_i = 0;
      p = c[2] ? 0 : c[1] ? 1 : c[0] ? 2 : last;
      settle(30);
      if (c == 0)      check_prf(p, "R6 held");
      else if (c[2])   check_prf(p, "R2 exec");
      else if (c[1])   check_prf(p, "R3 render");
      else             check_prf(p, "R4 display");
      last = p;
    end

    // R7 R5 R8: every ordered pair of profiles
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        set_prf(a); settle(40); check_prf(a, "R7 pair from");
        set_prf(b); settle(40); check_prf(b, "R7 pair to");
      end
    end

    // R5 exact idle threshold, R6 not idle
    idle_limit_i = 6;
    set_prf(0); settle(30);
    @(negedge clk); core_exec_i = 0; link_idle_i = 0;
    settle(8);
    chk(link_disc_o == 0, "R6 busy no entry", link_disc_o, 0);
    chk(width_up_o == 4, "R6 busy widths", width_up_o, 4);
    link_idle_i = 1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(link_disc_o == 0, "R5 limit edges", link_disc_o, 0);
    link_idle_i = 0;
    @(negedge clk); link_idle_i = 1;
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk(link_disc_o == 1, "R5 limit+1 edges", link_disc_o, 1);
    settle(5);
    chk(self_refresh_o == 1, "R5 self refresh", self_refresh_o, 1);

    // R8 wake: self-refresh off while still disconnected
    core_exec_i = 1; link_idle_i = 0;
    @(posedge clk); @(negedge clk);
    chk(self_refresh_o == 0, "R8 sr cleared", self_refresh_o, 0);
    chk(link_disc_o == 1, "R8 still disc", link_disc_o, 1);
    settle(20);
    check_prf(0, "R8 back to exec");

    // R7 acknowledge withheld
    hold_ack = 1;
    set_prf(1); settle(20);
    chk(link_disc_o == 1, "R7 wait ack disc", link_disc_o, 1);
    chk(width_up_o == 4, "R7 wait ack widths", width_up_o, 4);
    hold_ack = 0; settle(20);
    check_prf(1, "R7 after ack");

    // R7 ready withheld
    hold_ready = 1;
    set_prf(2); settle(20);
    check_prf(2, "R7 recon widths");
    set_prf(0); settle(20);
    check_prf(2, "R7 no chain before ready");
    hold_ready = 0; settle(30);
    check_prf(0, "R7 after ready");

    // R9 R10 hysteresis for several limits
    for (int i = 0; i < 3; i++) begin
      int lim;
      lim = (i == 0) ? 1 : (i == 1) ? 2 : 5;
      @(negedge clk); hyst_limit_i = CNT_W'(lim);
      over_temp_i = 1;
      @(posedge clk); @(negedge clk);
      chk(pstate_limit_o == 1, "R9 cap set", pstate_limit_o, 1);
      chk(mem_throttle_o == 0, "R10 no throttle from temp", mem_throttle_o, 0);
      mem_hot_i = 1;
      @(posedge clk); @(negedge clk);
      chk(mem_throttle_o == 1, "R10 throttle set", mem_throttle_o, 1);
      over_temp_i = 0; mem_hot_i = 0;
      if (lim > 1) begin
        repeat (lim - 1) @(posedge clk);
        @(negedge clk);
        chk(pstate_limit_o == 1, "R9 cap held", pstate_limit_o, 1);
        chk(mem_throttle_o == 1, "R10 throttle held", mem_throttle_o, 1);
      end
      @(posedge clk); @(negedge clk);
      if (lim == 1) begin
        chk(pstate_limit_o == 0, "R9 cap cleared", pstate_limit_o, 0);
        chk(mem_throttle_o == 0, "R10 throttle cleared", mem_throttle_o, 0);
      end else begin
        chk(pstate_limit_o == 0, "R9 cap cleared", pstate_limit_o, 0);
        chk(mem_throttle_o == 0, "R10 throttle cleared", mem_throttle_o, 0);
      end
      settle(3);
    end

    // R9 retrigger restarts the clear count (limit 5)
    @(negedge clk); over_temp_i = 1;
    @(negedge clk); over_temp_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); over_temp_i = 1;
    @(negedge clk); over_temp_i = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pstate_limit_o == 1, "R9 retrigger held", pstate_limit_o, 1);
    @(posedge clk); @(negedge clk);
    chk(pstate_limit_o == 0, "R9 retrigger cleared", pstate_limit_o, 0);

    chk(lane_viol == 0, "R7 widths moved on live link", lane_viol, 0);
    chk(sr_viol == 0, "R11 sr without disc", sr_viol, 0);
    chk(exit_viol == 0, "R8 sr left after reconnect", exit_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule